// File: doc/BRIEF.md
# Asynchronous Static RAM Port Controller

This block lets a clocked system read and write an external, unclocked static RAM of 2K words by 8 bits. A client presents one word request at a time on a valid/ready handshake. The controller then drives the memory address and the three active-low strobes (chip select, write enable, output enable) through a fixed sequence of phases, each a parameterised number of clock cycles. It drives the memory data bus only while write data must be on it, and releases the bus at all other times.

A write walks through an address setup phase, a write-enable pulse, a data hold phase and a recovery phase with chip select raised. A read holds chip select and output enable low for the access interval and captures the bus on its last cycle. Both operations end with a one-cycle done pulse, and the read word is presented alongside it. Between requests chip select stays high, so the memory sits in its low-power standby state. The address register only loads while chip select is high, so the address never moves while a write strobe overlap is active. Output enable stays high for the whole of every write, so the write pulse only has to meet the minimum pulse width.

Top module: `asram_port`

## Requirements
- R1: While reset is asserted, and on leaving reset, req_ready is 1, rsp_done is 0, mem_cs_n, mem_we_n and mem_oe_n are 1 and mem_dq_oe is 0.
- R2: A request is taken only on a rising edge where req_valid and req_ready are both 1. req_ready is 0 from the cycle after acceptance until the done cycle. Request inputs presented while req_ready is 0 change neither mem_addr nor mem_dq_o.
- R3: After a write is accepted there are SETUP_CYC cycles with mem_cs_n=0, mem_we_n=1. Then PULSE_CYC cycles with mem_we_n=0, then HOLD_CYC cycles with mem_cs_n=0, mem_we_n=1. Then RECOV_CYC cycles with mem_cs_n=1. Each count is raised to a minimum of 1, or 2 for PULSE_CYC.
- R4: mem_oe_n is 1 on every cycle of a write. mem_dq_oe is 1, with mem_dq_o equal to the accepted write data, from the second cycle of the write-enable pulse to the last hold cycle, and is 0 otherwise.
- R5: mem_addr equals the accepted request address on every cycle with mem_cs_n=0. It never changes between two consecutive cycles on which mem_cs_n and mem_we_n are both 0.
- R6: After a read is accepted there are ACCESS_CYC cycles with mem_cs_n=0, mem_oe_n=0, mem_we_n=1 and mem_dq_oe=0. rsp_rdata in the done cycle equals mem_dq_i sampled on the last of those cycles.
- R7: rsp_done is high for exactly one cycle, in the first cycle after the last read access cycle or the last write recovery cycle. req_ready is 1 in that cycle.
- R8: mem_dq_oe is never 1 while mem_oe_n is 0.
- R9: Whenever no request is in progress, mem_cs_n is 1 (standby) and the data bus is released.
- R10: A request presented during the done cycle is accepted on that edge and its first phase starts on the next cycle, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, can accept a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Data of the last completed read |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_o | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus pad |
| mem_dq_i | input | DATA_W | Data returned from the memory bus |

## Verification
The bench pairs the controller with a behavioural memory that decodes the strobes the way the device does. It also flags two faults. One is the controller driving the bus while the memory drives it on a read. The other is an address change while chip select and write enable are both low. Back-to-back requests issued in the done cycle catch a design that adds an idle cycle or drops the second request. Request inputs are scrambled while busy, which would expose a design that reloads the address mid-write and corrupts the wrong word. Phase counts other than the defaults are used, so an off-by-one in any phase shows up as a strobe edge one cycle early or late. A write followed at once by a read of the same address exposes a capture made on the wrong cycle or data that is not held long enough.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WSETUP  = 3'd1,
    ST_WSTROBE = 3'd2,
    ST_WDRIVE  = 3'd3,
    ST_WHOLD   = 3'd4,
    ST_WRECOV  = 3'd5,
    ST_RACCESS = 3'd6
  } ctl_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int at_least(input int v, input int floor_v);
    return (v < floor_v) ? floor_v : v;
  endfunction

endpackage

// File: rtl/asram_rst_sync.sv
module asram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/asram_interval_timer.sv
module asram_interval_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int S_C   = 1,
  parameter int P_C   = 2,
  parameter int H_C   = 1,
  parameter int R_C   = 1,
  parameter int A_C   = 2,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             t_zero,
  output ctl_state_e       st,
  output logic             t_load,
  output logic [CNT_W-1:0] t_val,
  output logic             accept,
  output logic             finish,
  output logic             capture
);
  localparam logic [CNT_W-1:0] V_SETUP  = CNT_W'(S_C - 1);
  localparam logic [CNT_W-1:0] V_DRIVE  = CNT_W'(P_C - 2);
  localparam logic [CNT_W-1:0] V_HOLD   = CNT_W'(H_C - 1);
  localparam logic [CNT_W-1:0] V_RECOV  = CNT_W'(R_C - 1);
  localparam logic [CNT_W-1:0] V_ACCESS = CNT_W'(A_C - 1);

  ctl_state_e st_q, st_d;

  always_comb begin
    st_d    = st_q;
    t_load  = 1'b0;
    t_val   = '0;
    accept  = 1'b0;
    finish  = 1'b0;
    capture = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          t_load = 1'b1;
          if (req_write) begin
            st_d  = ST_WSETUP;
            t_val = V_SETUP;
          end else begin
            st_d  = ST_RACCESS;
            t_val = V_ACCESS;
          end
        end
      end
      ST_WSETUP: begin
        if (t_zero) st_d = ST_WSTROBE;
      end
      ST_WSTROBE: begin
        st_d   = ST_WDRIVE;
        t_load = 1'b1;
        t_val  = V_DRIVE;
      end
      ST_WDRIVE: begin
        if (t_zero) begin
          st_d   = ST_WHOLD;
          t_load = 1'b1;
          t_val  = V_HOLD;
        end
      end
      ST_WHOLD: begin
        if (t_zero) begin
          st_d   = ST_WRECOV;
          t_load = 1'b1;
          t_val  = V_RECOV;
        end
      end
      ST_WRECOV: begin
        if (t_zero) begin
          st_d   = ST_IDLE;
          finish = 1'b1;
        end
      end
      ST_RACCESS: begin
        if (t_zero) begin
          st_d    = ST_IDLE;
          finish  = 1'b1;
          capture = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign st = st_q;

  // R7: a completing operation always lands back in idle
  p_finish_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (st_q == ST_IDLE));

  // R4: the strobe-only cycle is always followed by the driven pulse cycles
  p_strobe_then_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WSTROBE) |=> (st_q == ST_WDRIVE));
endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              is_write,
  input  logic              capture,
  input  logic              finish,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              done_q;
  logic              wdata_en;

  assign wdata_en = accept && is_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (accept) addr_q <= req_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wdata_q <= '0;
    else if (wdata_en) wdata_q <= req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= mem_dq_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= finish;
  end

  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign rsp_rdata = rdata_q;
  assign rsp_done  = done_q;

  // R6: returned data only moves in the cycle a read completes
  p_rdata_moves_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata_q) |-> done_q);
endmodule

// File: rtl/asram_port.sv
module asram_port
  import asram_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int SETUP_CYC  = 1,
  parameter int PULSE_CYC  = 2,
  parameter int HOLD_CYC   = 1,
  parameter int RECOV_CYC  = 1,
  parameter int ACCESS_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int S_C   = at_least(SETUP_CYC, 1);
  localparam int P_C   = at_least(PULSE_CYC, 2);
  localparam int H_C   = at_least(HOLD_CYC, 1);
  localparam int R_C   = at_least(RECOV_CYC, 1);
  localparam int A_C   = at_least(ACCESS_CYC, 1);
  localparam int MAXC  = max2(max2(max2(S_C, P_C), max2(H_C, R_C)), A_C);
  localparam int CNT_W = $clog2(MAXC + 1);

  logic             rst_i_n;
  ctl_state_e       st;
  logic             t_load, t_zero;
  logic [CNT_W-1:0] t_val;
  logic             accept, finish, capture;

  asram_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  asram_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  asram_seq #(
    .S_C(S_C), .P_C(P_C), .H_C(H_C), .R_C(R_C), .A_C(A_C), .CNT_W(CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .t_zero    (t_zero),
    .st        (st),
    .t_load    (t_load),
    .t_val     (t_val),
    .accept    (accept),
    .finish    (finish),
    .capture   (capture)
  );

  asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .accept    (accept),
    .is_write  (req_write),
    .capture   (capture),
    .finish    (finish),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_dq_i  (mem_dq_i),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .rsp_rdata (rsp_rdata),
    .rsp_done  (rsp_done)
  );

  // Strobe decode from the registered state: no combinational path from
  // request inputs to the memory pins.
  always_comb begin
    mem_cs_n  = 1'b1;
    mem_we_n  = 1'b1;
    mem_oe_n  = 1'b1;
    mem_dq_oe = 1'b0;
    unique case (st)
      ST_WSETUP:  mem_cs_n = 1'b0;
      ST_WSTROBE: begin mem_cs_n = 1'b0; mem_we_n = 1'b0; end
      ST_WDRIVE:  begin mem_cs_n = 1'b0; mem_we_n = 1'b0; mem_dq_oe = 1'b1; end
      ST_WHOLD:   begin mem_cs_n = 1'b0; mem_dq_oe = 1'b1; end
      ST_RACCESS: begin mem_cs_n = 1'b0; mem_oe_n = 1'b0; end
      default: ;
    endcase
  end

  assign req_ready = (st == ST_IDLE);

  // R5: no address movement inside a write overlap
  p_addr_still_in_overlap_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!mem_cs_n && !mem_we_n) |=> ((mem_cs_n || mem_we_n) || $stable(mem_addr)));

  // R5: address only moves while deselected
  p_addr_moves_deselected_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    !$stable(mem_addr) |-> $past(mem_cs_n));

  // R4: output enable stays high whenever write enable is low
  p_oe_high_in_write_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    !mem_we_n |-> mem_oe_n);

  // R4: bus drive begins only on a cycle after write enable already fell
  p_drive_after_we_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(mem_dq_oe) |-> (!mem_we_n && $past(!mem_we_n)));

  // R8: never fight the memory on a read
  p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    !mem_oe_n |-> !mem_dq_oe);

  // R9: idle means standby with the bus released
  p_idle_standby_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    req_ready |-> (mem_cs_n && !mem_dq_oe));

  // R7: completion pulse lasts one cycle
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    rsp_done |=> !rsp_done);

  // R2: once busy, ready stays low until the completion cycle
  p_busy_until_done_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!req_ready && !finish) |=> !req_ready);
endmodule

// File: tb/asram_port_test.sv
module asram_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int SC = 2;
  localparam int PC = 3;
  localparam int HC = 2;
  localparam int RC = 1;
  localparam int AC = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          req_ready, rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_o, mem_dq_i;

  always #(CLK_PERIOD/2) clk = ~clk;

  asram_port #(
    .ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(SC), .PULSE_CYC(PC),
    .HOLD_CYC(HC), .RECOV_CYC(RC), .ACCESS_CYC(AC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // Behavioural memory: decodes the strobes like the device.
  logic [DW-1:0] mem_model [2**AW];
  logic [DW-1:0] shadow    [2**AW];
  logic          model_drv;

  assign model_drv = !mem_cs_n && !mem_oe_n && mem_we_n;
  assign mem_dq_i  = model_drv ? mem_model[mem_addr] : '0;

  always @(posedge clk) begin
    if (!mem_cs_n && !mem_we_n && mem_dq_oe) mem_model[mem_addr] <= mem_dq_o;
  end

  // Expected per-cycle view: flags = {cs_n, we_n, oe_n, dq_oe, ready, done}
  typedef struct {
    logic [5:0] f;
    int         a;
    int         w;
    int         d;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   vectors = 0;
  int   misses  = 0;
  bit   in_reset;
  logic          prev_overlap;
  logic [AW-1:0] prev_addr;

  task automatic fail_line(input string tag, input string what, input int act, input int exp);
    misses++;
    $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
  endtask

  task automatic compare_cycle();
    exp_t       e;
    logic [5:0] act;
    if (q.size() > 0) e = q.pop_front();
    else begin
      e.f = 6'b111010; e.a = -1; e.w = -1; e.d = -1;
      e.tag = in_reset ? "R1" : "R9";
    end
    act = {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_done};
    vectors++;
    if (act !== e.f) fail_line(e.tag, "strobes{cs,we,oe,dqoe,rdy,done}", int'(act), int'(e.f));
    if (e.a >= 0 && mem_addr !== AW'(e.a)) fail_line("R5", "mem_addr", int'(mem_addr), e.a);
    if (e.w >= 0 && mem_dq_o !== DW'(e.w)) fail_line("R4", "mem_dq_o", int'(mem_dq_o), e.w);
    if (e.d >= 0 && rsp_rdata !== DW'(e.d)) fail_line("R6", "rsp_rdata", int'(rsp_rdata), e.d);
    if (model_drv && mem_dq_oe) fail_line("R8", "bus contention", 1, 0);
    if (prev_overlap && !mem_cs_n && !mem_we_n && mem_addr !== prev_addr)
      fail_line("R5", "addr moved in overlap", int'(mem_addr), int'(prev_addr));
    prev_overlap = !mem_cs_n && !mem_we_n;
    prev_addr    = mem_addr;
  endtask

  task automatic step();
    @(negedge clk);
    compare_cycle();
  endtask

  task automatic push(input logic [5:0] f, input int a, input int w, input int d, input string tag);
    exp_t e;
    e.f = f; e.a = a; e.w = w; e.d = d; e.tag = tag;
    q.push_back(e);
  endtask

  // Called right after a compare; accepted at the coming rising edge.
  task automatic issue(input bit wr, input int a, input int d);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = DW'(d);
    while (!req_ready) step();
    if (wr) begin
      shadow[a] = DW'(d);
      for (int i = 0; i < SC; i++)     push(6'b011000, a, -1, -1, "R3");
      push(6'b001000, a, -1, -1, "R4");
      for (int i = 1; i < PC; i++)     push(6'b001100, a, d, -1, "R4");
      for (int i = 0; i < HC; i++)     push(6'b011100, a, d, -1, "R3");
      for (int i = 0; i < RC; i++)     push(6'b111000, -1, -1, -1, "R3");
      push(6'b111011, -1, -1, -1, "R7");
    end else begin
      for (int i = 0; i < AC; i++)     push(6'b010000, a, -1, -1, "R6");
      push(6'b111011, -1, -1, int'(shadow[a]), "R6");
    end
    step();
    // R2: scramble request inputs while busy; they must be ignored
    req_valid = 1'b0; req_write = ~wr; req_addr = ~AW'(a); req_wdata = ~DW'(d);
  endtask

  task automatic drain();
    while (q.size() != 0) step();
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    misses++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2**AW; i++) begin mem_model[i] = '0; shadow[i] = '0; end
    prev_overlap = 1'b0; prev_addr = '0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    in_reset = 1'b1;
    rst_n = 1'b0;
    for (int i = 0; i < 4; i++) step();          // R1 reset state
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step();          // R1 after release
    in_reset = 1'b0;
    for (int i = 0; i < 3; i++) step();          // R9 standby idle

    // R3 R4 R6: single write and read at the lowest address
    issue(1'b1, 0, 8'hA5); drain();
    issue(1'b0, 0, 0);     drain();
    // boundary: top address, then a never-written address reads zero
    issue(1'b1, 2047, 8'h5A); drain();
    issue(1'b0, 2047, 0);     drain();
    issue(1'b0, 12'h123, 0);  drain();

    // R10: chained requests presented in each done cycle
    issue(1'b1, 12'h155, 8'h3C);
    issue(1'b1, 12'h2AA, 8'hC3);
    issue(1'b0, 12'h155, 0);
    issue(1'b0, 12'h2AA, 0);
    issue(1'b1, 12'h155, 8'hFF);   // overwrite
    issue(1'b0, 12'h155, 0);
    drain();

    // pattern sweep: writes then reads, all chained
    for (int i = 0; i < 16; i++) issue(1'b1, (i * 389 + 7) % 2048, (i * 37 + 5) % 256);
    for (int i = 0; i < 16; i++) issue(1'b0, (i * 389 + 7) % 2048, 0);
    drain();
    // write then immediate read of the same word
    issue(1'b1, 12'h400, 8'h81);
    issue(1'b0, 12'h400, 0);
    drain();
    for (int i = 0; i < 4; i++) step();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule